// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

The engine feeds a transmitter from a circular ring of 8-byte buffer descriptors kept in memory. It reads each descriptor over a word-wide request/acknowledge port and checks that the processor has handed it over. It then reads the data buffer one word at a time and pushes the words into an internal transmit FIFO. After the data of a frame's final descriptor, it pushes a tagged end-of-frame entry. The engine keeps fetching descriptors and data for as long as the FIFO has room. It halts when it reads a descriptor that the processor still owns. A pulse on `start_i` sets it running again.

The engine returns a descriptor to the processor in one of two ways. A descriptor that does not end a frame is written back at once, with its ownership bit cleared. A descriptor that ends a frame is held in a small pending queue. It is written back only when the modelled transmitter reports that the frame is complete, and the write-back carries the reported error and retry status. Each such write-back raises a one-cycle interrupt pulse.

Fetching runs ahead of write-back and does not check which descriptors are still pending. In a short ring, a descriptor that has not yet been written back is therefore read again with ownership still set, and its frame is sent again. A bus error response stops the engine for good and raises a sticky flag.

Top module: `txr_dma`

## Requirements
- R1: After reset, mem_req_o, txq_valid_o, irq_o and err_o are low, and no memory request is made until start_i is pulsed.
- R2: A descriptor is two words. The word at offset 0 holds the status halfword in bits 31:16 and the byte length in bits 15:0. The word at offset 4 holds the buffer address. The data is read as ceil(length/4) words from that address and appears on txq_data_o in address order, with txq_eof_o low.
- R3: If bit 31 (owned) of a descriptor word 0 reads as 0, the engine stops fetching. A later start_i pulse resumes by re-reading that same descriptor.
- R4: After a descriptor with bit 29 (wrap) set, the next descriptor is read at ring_base_i. Otherwise the next descriptor is read 8 bytes further on.
- R5: After the data of a descriptor with bit 27 (last) set, one entry is pushed with txq_eof_o high and txq_data_o zero.
- R6: A descriptor with bit 27 clear is written back as soon as its data has been read. The written word 0 has bit 31 cleared and all other bits unchanged.
- R7: A descriptor with bit 27 set is written back only after a txs_valid_i pulse. Frames complete in the order they were fetched. The written word 0 is {0, original bits 30:26, txs_status_i[9:0], original length}. irq_o pulses for one cycle after that write is acknowledged.
- R8: The FIFO holds 48 words (192 bytes). While it is full, no data word is read. Reading resumes as entries are drained, and no entry is lost or duplicated.
- R9: The engine does not check whether a descriptor is still pending. In a two-entry ring whose descriptors are both last and owned, frames repeat until four completions are pending. The engine halts when it reads a written-back descriptor.
- R10: A zero-length descriptor with bit 27 clear pushes nothing, reads no data and is written back at once.
- R11: An error response to any request sets err_o. err_o stays set until reset, no further request is made, and start_i has no effect.
- R12: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_we_o and mem_addr_o are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that sets the engine running |
| ring_base_i | input | AW | Byte address of the first descriptor |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Error response, valid with mem_ack_i |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| txq_valid_o | output | 1 | FIFO head entry valid |
| txq_data_o | output | 32 | FIFO head data |
| txq_eof_o | output | 1 | FIFO head is an end-of-frame marker |
| txq_ready_i | input | 1 | Transmitter takes the head entry |
| txs_valid_i | input | 1 | Frame completion report |
| txs_status_i | input | 10 | Error and retry status of the completed frame |
| irq_o | output | 1 | One-cycle pulse per frame write-back |
| err_o | output | 1 | Sticky bus error flag |

## Verification
The main coincidence is at the FIFO full boundary, where the engine pushes a freshly read data word in the same cycle that the transmitter pops the head entry. The bench provokes it by holding txq_ready_i low until a 240-byte frame has filled the FIFO, then draining continuously while the engine refills. The result is judged in two ways: the count of data reads made during the stall must equal the FIFO depth, and the full word stream must come out in order with nothing lost or repeated. A second overlap, between prefetch and still-pending descriptors, is provoked with a two-entry ring whose completions are held back, and it is judged from the repeated frames and the final descriptor words.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned RDY_B  = 31;
  localparam int unsigned WRAP_B = 29;
  localparam int unsigned LAST_B = 27;
  localparam int unsigned ERR_W  = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_D0, S_D1, S_DATA, S_EOF, S_WBN, S_WBL
  } state_e;

  typedef struct packed {
    logic        eof;
    logic [31:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/txr_fifo.sv
module txr_fifo import txr_pkg::*; #(
  parameter int unsigned DEPTH = 48
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  fifo_ent_t din_i,
  output logic      full_o,
  input  logic      pop_i,
  output logic      valid_o,
  output fifo_ent_t dout_o
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  fifo_ent_t         mem_q [DEPTH];
  logic [IW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == IW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == IW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end
endmodule

// File: rtl/txr_pend_q.sv
// Frames awaiting completion: enqueue at EOF, mark done on report, dequeue on write-back.
module txr_pend_q import txr_pkg::*; #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic [AW-1:0]    enq_addr_i,
  input  logic [31:0]      enq_w0_i,
  input  logic             done_i,
  input  logic [ERR_W-1:0] done_st_i,
  input  logic             deq_i,
  output logic             full_o,
  output logic             wb_pend_o,
  output logic [AW-1:0]    hd_addr_o,
  output logic [31:0]      hd_w0_o,
  output logic [ERR_W-1:0] hd_st_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [31:0]      w0_q   [DEPTH];
  logic [ERR_W-1:0] st_q   [DEPTH];
  logic [PW:0]      wr_q, dn_q, rd_q;
  logic             done_ok;

  assign full_o    = ((wr_q - rd_q) == (PW+1)'(DEPTH));
  assign wb_pend_o = (rd_q != dn_q);
  assign done_ok   = done_i && (dn_q != wr_q);
  assign hd_addr_o = addr_q[rd_q[PW-1:0]];
  assign hd_w0_o   = w0_q[rd_q[PW-1:0]];
  assign hd_st_o   = st_q[rd_q[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      dn_q <= '0;
      rd_q <= '0;
    end else begin
      if (enq_i)   wr_q <= wr_q + 1'b1;
      if (done_ok) dn_q <= dn_q + 1'b1;
      if (deq_i)   rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (enq_i) begin
      addr_q[wr_q[PW-1:0]] <= enq_addr_i;
      w0_q[wr_q[PW-1:0]]   <= enq_w0_i;
    end
    if (done_ok) st_q[dn_q[PW-1:0]] <= done_st_i;
  end
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl import txr_pkg::*; #(
  parameter int unsigned AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             fifo_full_i,
  output logic             push_o,
  output fifo_ent_t        push_ent_o,
  input  logic             pq_full_i,
  input  logic             wb_pend_i,
  input  logic [AW-1:0]    wb_addr_i,
  input  logic [31:0]      wb_w0_i,
  input  logic [ERR_W-1:0] wb_st_i,
  output logic             enq_o,
  output logic [AW-1:0]    cur_addr_o,
  output logic [31:0]      cur_w0_o,
  output logic             deq_o,
  output logic             irq_o,
  output logic             err_o
);
  state_e        state_q;
  logic          run_q, err_q, irq_q;
  logic [AW-1:0] off_q, ptr_q, nxt_off;
  logic [31:0]   w0_q;
  logic [14:0]   cnt_q;
  logic [16:0]   len_w;
  logic          ok, berr;

  assign cur_addr_o = base_i + off_q;
  assign cur_w0_o   = w0_q;
  assign nxt_off    = w0_q[WRAP_B] ? '0 : off_q + AW'(8);
  assign len_w      = {1'b0, w0_q[15:0]} + 17'd3;
  assign ok         = mem_req_o && mem_ack_i && !mem_err_i;
  assign berr       = mem_req_o && mem_ack_i && mem_err_i;
  assign irq_o      = irq_q;
  assign err_o      = err_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_addr_o;
    mem_wdata_o = {1'b0, w0_q[30:0]};
    push_o      = 1'b0;
    push_ent_o  = '{eof: 1'b0, data: mem_rdata_i};
    enq_o       = 1'b0;
    deq_o       = 1'b0;
    unique case (state_q)
      S_D0:   mem_req_o = 1'b1;
      S_D1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_addr_o + AW'(4);
      end
      S_DATA: begin
        mem_req_o  = (cnt_q != '0) && !fifo_full_i;
        mem_addr_o = ptr_q;
        push_o     = mem_req_o && mem_ack_i && !mem_err_i;
      end
      S_EOF: begin
        push_o     = !fifo_full_i;
        push_ent_o = '{eof: 1'b1, data: 32'h0};
        enq_o      = !fifo_full_i;
      end
      S_WBN: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      S_WBL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = wb_addr_i;
        mem_wdata_o = {1'b0, wb_w0_i[30:26], wb_st_i, wb_w0_i[15:0]};
        deq_o       = mem_ack_i && !mem_err_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      off_q   <= '0;
      ptr_q   <= '0;
      w0_q    <= '0;
      cnt_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (!err_q) begin
          // completions first so pending frames never starve
          if (wb_pend_i) state_q <= S_WBL;
          else if (run_q && !fifo_full_i && !pq_full_i) state_q <= S_D0;
        end
        S_D0: if (ok) begin
          w0_q <= mem_rdata_i;
          if (mem_rdata_i[RDY_B]) state_q <= S_D1;
          else begin
            run_q   <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        S_D1: if (ok) begin
          ptr_q   <= AW'(mem_rdata_i);
          cnt_q   <= len_w[16:2];
          state_q <= S_DATA;
        end
        S_DATA: begin
          if (cnt_q == '0) state_q <= w0_q[LAST_B] ? S_EOF : S_WBN;
          else if (ok) begin
            ptr_q <= ptr_q + AW'(4);
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_EOF: if (!fifo_full_i) begin
          off_q   <= nxt_off;
          state_q <= S_IDLE;
        end
        S_WBN: if (ok) begin
          off_q   <= nxt_off;
          state_q <= S_IDLE;
        end
        S_WBL: if (ok) begin
          irq_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
      if (berr) begin
        err_q   <= 1'b1;
        run_q   <= 1'b0;
        state_q <= S_IDLE;
      end else if (start_i && !err_q) begin
        run_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txr_dma.sv
module txr_dma import txr_pkg::*; #(
  parameter int unsigned AW         = 32,
  parameter int unsigned FIFO_BYTES = 192,
  parameter int unsigned PEND_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    ring_base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             txq_valid_o,
  output logic [31:0]      txq_data_o,
  output logic             txq_eof_o,
  input  logic             txq_ready_i,
  input  logic             txs_valid_i,
  input  logic [ERR_W-1:0] txs_status_i,
  output logic             irq_o,
  output logic             err_o
);
  localparam int unsigned FIFO_WORDS = FIFO_BYTES / 4;

  logic             fifo_push, fifo_full;
  fifo_ent_t        fifo_din, fifo_dout;
  logic             pq_full, wb_pend, enq, deq;
  logic [AW-1:0]    wb_addr, cur_addr;
  logic [31:0]      wb_w0, cur_w0;
  logic [ERR_W-1:0] wb_st;

  assign txq_data_o = fifo_dout.data;
  assign txq_eof_o  = fifo_dout.eof;

  txr_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .base_i(ring_base_i),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .fifo_full_i(fifo_full), .push_o(fifo_push), .push_ent_o(fifo_din),
    .pq_full_i(pq_full), .wb_pend_i(wb_pend), .wb_addr_i(wb_addr),
    .wb_w0_i(wb_w0), .wb_st_i(wb_st),
    .enq_o(enq), .cur_addr_o(cur_addr), .cur_w0_o(cur_w0), .deq_o(deq),
    .irq_o, .err_o
  );

  txr_fifo #(.DEPTH(FIFO_WORDS)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_push), .din_i(fifo_din), .full_o(fifo_full),
    .pop_i(txq_ready_i), .valid_o(txq_valid_o), .dout_o(fifo_dout)
  );

  txr_pend_q #(.DEPTH(PEND_DEPTH), .AW(AW)) u_pend (
    .clk_i, .rst_ni,
    .enq_i(enq), .enq_addr_i(cur_addr), .enq_w0_i(cur_w0),
    .done_i(txs_valid_i), .done_st_i(txs_status_i), .deq_i(deq),
    .full_o(pq_full), .wb_pend_o(wb_pend),
    .hd_addr_o(wb_addr), .hd_w0_o(wb_w0), .hd_st_o(wb_st)
  );
endmodule

// File: rtl/txr_dma_chk.sv
module txr_dma_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          txq_valid_o,
  input logic          txq_eof_o,
  input logic [31:0]   txq_data_o,
  input logic          irq_o,
  input logic          err_o,
  input logic          fifo_push,
  input logic          fifo_full
);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));
  // R6
  wb_rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);
  // R7
  irq_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R11
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_push && fifo_full));
  // R5
  eof_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txq_valid_o && txq_eof_o |-> txq_data_o == 32'h0);
endmodule

bind txr_dma txr_dma_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .txq_valid_o(txq_valid_o), .txq_eof_o(txq_eof_o), .txq_data_o(txq_data_o),
  .irq_o(irq_o), .err_o(err_o), .fifo_push(fifo_push), .fifo_full(fifo_full)
);

// File: tb/sim_txr_dma.sv
`timescale 1ns/1ps
module sim_txr_dma;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        req, we, ack = 1'b0, merr = 1'b0;
  logic [31:0] addr, wdata, rdata = '0;
  logic        qv, qeof, qready = 1'b1;
  logic [31:0] qdata;
  logic        sv = 1'b0;
  logic [9:0]  sst = '0;
  logic        irq, err;

  logic [31:0] mem [256];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0, err_addr = 32'hFFFF_FFFF;
  logic [31:0] rd_log [1024];
  logic [32:0] q_log  [1024];
  int          rd_n = 0, q_n = 0, irq_n = 0, hold_viol = 0;
  logic        wait_q = 1'b0;
  logic [31:0] addr_q = '0;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  txr_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ring_base_i(32'h0),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_err_i(merr), .mem_rdata_i(rdata),
    .txq_valid_o(qv), .txq_data_o(qdata), .txq_eof_o(qeof), .txq_ready_i(qready),
    .txs_valid_i(sv), .txs_status_i(sst), .irq_o(irq), .err_o(err)
  );

  // memory and transmitter model
  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      merr <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      ack  <= req && !ack;
      merr <= req && !ack && (addr == err_addr);
      if (req && !ack && !we) rdata <= mem[addr[9:2]];
      if (req && ack && we) mem[addr[9:2]] <= wdata;
      if (req && ack && !we) begin
        rd_log[rd_n] <= addr;
        rd_n <= rd_n + 1;
      end
      if (bd_we) mem[bd_addr[9:2]] <= bd_data;
      if (qv && qready) begin
        q_log[q_n] <= {qeof, qdata};
        q_n <= q_n + 1;
      end
      if (irq) irq_n <= irq_n + 1;
      if (wait_q && addr != addr_q) hold_viol <= hold_viol + 1;
      wait_q <= req && !ack;
      addr_q <= addr;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic desc(input int idx, input logic [31:0] w0, input logic [31:0] ptr);
    poke(32'(idx * 8), w0);
    poke(32'(idx * 8 + 4), ptr);
  endtask

  task automatic fill(input logic [31:0] ptr, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) poke(ptr + 32'(4 * i), seed + 32'(i));
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic complete(input logic [9:0] s);
    sv = 1'b1; sst = s;
    @(negedge clk);
    sv = 1'b0;
    cyc(20);
  endtask

  task automatic t_reset();
    cyc(5);
    rst_n = 1'b1;
    cyc(10);
    chk("R1 req", 64'(req), 64'd0);
    chk("R1 txq_valid", 64'(qv), 64'd0);
    chk("R1 irq/err", 64'({irq, err}), 64'd0);
    chk("R1 no reads", 64'(rd_n), 64'd0);
  endtask

  task automatic t_single();
    int q0, r0, i0;
    desc(0, 32'hC800_000A, 32'h100);
    desc(1, 32'h0000_0000, 32'h0);
    desc(2, 32'h2000_0000, 32'h0);
    fill(32'h100, 3, 32'hA000_0000);
    q0 = q_n; i0 = irq_n;
    kick();
    cyc(100);
    chk("R2 count", 64'(q_n - q0), 64'd4);
    for (int k = 0; k < 3; k++) chk("R2 data", 64'(q_log[q0 + k]), 64'({1'b0, 32'hA000_0000 + 32'(k)}));
    chk("R5 eof", 64'(q_log[q0 + 3]), 64'({1'b1, 32'h0}));
    chk("R3 halt addr", 64'(rd_log[rd_n - 1]), 64'h8);
    r0 = rd_n;
    cyc(50);
    chk("R3 stays halted", 64'(rd_n), 64'(r0));
    chk("R7 held until done", 64'(mem[0]), 64'hC800_000A);
    complete(10'h155);
    chk("R7 wb word", 64'(mem[0]), 64'h4955_000A);
    chk("R7 irq", 64'(irq_n - i0), 64'd1);
  endtask

  task automatic t_nonlast();
    int q0, r0;
    desc(1, 32'h8000_0008, 32'h140);
    desc(2, 32'hA800_0004, 32'h180);
    fill(32'h140, 2, 32'hB000_0000);
    fill(32'h180, 1, 32'hC000_0000);
    q0 = q_n; r0 = rd_n;
    kick();
    cyc(150);
    chk("R3 resume addr", 64'(rd_log[r0]), 64'h8);
    chk("R2 count", 64'(q_n - q0), 64'd4);
    chk("R2 b0", 64'(q_log[q0]), 64'({1'b0, 32'hB000_0000}));
    chk("R2 b1", 64'(q_log[q0 + 1]), 64'({1'b0, 32'hB000_0001}));
    chk("R2 c0", 64'(q_log[q0 + 2]), 64'({1'b0, 32'hC000_0000}));
    chk("R5 eof", 64'(q_log[q0 + 3]), 64'({1'b1, 32'h0}));
    chk("R6 early wb", 64'(mem[2]), 64'h0000_0008);
    chk("R4 wrap to base", 64'(rd_log[rd_n - 1]), 64'h0);
    complete(10'h3FF);
    chk("R7 wb word", 64'(mem[4]), 64'h2BFF_0004);
  endtask

  task automatic t_zero();
    int q0, r0, hits;
    desc(0, 32'h8000_0000, 32'h300);
    desc(1, 32'h8800_0004, 32'h1C0);
    desc(2, 32'h2000_0000, 32'h0);
    fill(32'h1C0, 1, 32'hD000_0000);
    q0 = q_n; r0 = rd_n;
    kick();
    cyc(120);
    chk("R10 count", 64'(q_n - q0), 64'd2);
    chk("R10 data", 64'(q_log[q0]), 64'({1'b0, 32'hD000_0000}));
    chk("R10 released", 64'(mem[0]), 64'h0);
    hits = 0;
    for (int k = r0; k < rd_n; k++) if (rd_log[k] == 32'h300) hits++;
    chk("R10 no data read", 64'(hits), 64'd0);
    chk("R3 halt addr", 64'(rd_log[rd_n - 1]), 64'h10);
    complete(10'h000);
    chk("R7 wb word", 64'(mem[2]), 64'h0800_0004);
  endtask

  task automatic t_backpressure();
    int q0, r0, dr;
    qready = 1'b0;
    desc(2, 32'hA800_00F0, 32'h100);
    fill(32'h100, 60, 32'hE000_0000);
    q0 = q_n; r0 = rd_n;
    kick();
    cyc(300);
    dr = 0;
    for (int k = r0; k < rd_n; k++) if (rd_log[k] >= 32'h100 && rd_log[k] < 32'h200) dr++;
    chk("R8 reads capped at depth", 64'(dr), 64'd48);
    chk("R8 nothing popped", 64'(q_n - q0), 64'd0);
    qready = 1'b1;
    cyc(400);
    chk("R8 total", 64'(q_n - q0), 64'd61);
    for (int k = 0; k < 60; k++) chk("R8 order", 64'(q_log[q0 + k]), 64'({1'b0, 32'hE000_0000 + 32'(k)}));
    chk("R5 eof", 64'(q_log[q0 + 60]), 64'({1'b1, 32'h0}));
    chk("R4 wrap halt", 64'(rd_log[rd_n - 1]), 64'h0);
    complete(10'h001);
    chk("R7 wb word", 64'(mem[4]), 64'h2801_00F0);
  endtask

  task automatic t_ring2();
    int q0, i0;
    desc(0, 32'h8800_0004, 32'h200);
    desc(1, 32'hA800_0004, 32'h240);
    fill(32'h200, 1, 32'hF000_0000);
    fill(32'h240, 1, 32'h6000_0000);
    q0 = q_n; i0 = irq_n;
    kick();
    cyc(250);
    chk("R9 repeated frames", 64'(q_n - q0), 64'd8);
    for (int f = 0; f < 4; f++) begin
      chk("R9 frame data", 64'(q_log[q0 + 2 * f]),
          64'({1'b0, (f % 2 == 0) ? 32'hF000_0000 : 32'h6000_0000}));
      chk("R9 frame eof", 64'(q_log[q0 + 2 * f + 1]), 64'({1'b1, 32'h0}));
    end
    chk("R9 still owned", 64'(mem[0]), 64'h8800_0004);
    complete(10'h010);
    complete(10'h020);
    complete(10'h030);
    complete(10'h040);
    chk("R9 stopped", 64'(q_n - q0), 64'd8);
    chk("R9 d0 final", 64'(mem[0]), 64'h0830_0004);
    chk("R9 d1 final", 64'(mem[2]), 64'h2840_0004);
    chk("R7 irq count", 64'(irq_n - i0), 64'd4);
  endtask

  task automatic t_buserr();
    int q0, r0;
    desc(0, 32'h8800_0008, 32'h280);
    fill(32'h280, 2, 32'h7000_0000);
    err_addr = 32'h284;
    q0 = q_n;
    kick();
    cyc(60);
    chk("R11 err set", 64'(err), 64'd1);
    chk("R11 partial", 64'(q_n - q0), 64'd1);
    chk("R11 quiet", 64'(req), 64'd0);
    r0 = rd_n;
    kick();
    cyc(30);
    chk("R11 start ignored", 64'(rd_n), 64'(r0));
    chk("R11 sticky", 64'(err), 64'd1);
    chk("R12 request held", 64'(hold_viol), 64'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_nonlast();
        t_zero();
        t_backpressure();
        t_ring2();
        t_buserr();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule